// File: doc/BRIEF.md
# Side-Effect-Aware Store Buffer

This block sits between a load/store pipeline and a memory port. Stores arrive with an address, a 16-byte lane mask, 128 bits of data, a cacheable flag and a side-effect flag. The block parks them in a short in-order queue and presents the oldest entry to memory over a valid/ready handshake. Each entry covers one 16-byte aligned line, and the port always carries the line-aligned address.

Cacheable stores may combine with the youngest pending entry when that entry covers the same line. That entry must also not be the one being offered to memory. Noncacheable stores never combine, so each keeps its own entry and its original byte mask. The block also decides, in the same cycle, whether a presented load may issue. A noncacheable load waits behind every pending noncacheable store. A noncacheable side-effect load also waits for a pipeline signal saying that all earlier branches and exceptions are settled. A cacheable load waits while any pending entry covers its line, because no data is forwarded. A speculative (non-faulting) load to a side-effect page never issues: in its own cycle the block answers with a fault pulse that carries code 2 and the load address.

Top module: `sefx_store_buffer`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `mem_valid` is 0, `st_ready` is 1 and `flt_valid` is 0.
- R2: A cacheable store merges into the youngest pending entry when that entry is cacheable and covers the same line (address bits above bit 3), and at least two entries are pending. The masks are ORed and the bytes of the newer store replace the older bytes.
- R3: A noncacheable store always takes a fresh entry with its mask unchanged. No store ever merges into a noncacheable entry. `mem_uncached` is 1 for such entries.
- R4: Entries leave strictly oldest first. `mem_valid` is 1 whenever an entry is pending. An entry is removed on a cycle with `mem_valid` and `mem_ready` both high. While it is waiting, the offered entry does not change. `mem_addr` has its low 4 bits at zero.
- R5: When 4 entries are pending and the store cannot merge, `st_ready` is 0 and the store is not taken.
- R6: A noncacheable load is not granted while any noncacheable store is pending.
- R7: A noncacheable load with the side-effect flag set is not granted while `ctl_resolved` is 0.
- R8: A load with `ld_nonfaulting` and `ld_side_effect` both set is never granted. In the same cycle `flt_valid` is 1, `flt_code` is 2'd2 and `flt_addr` equals `ld_addr`.
- R9: A cacheable load is not granted while any pending entry covers the same 16-byte line.
- R10: A presented load with none of the hazards of R6 to R9 is granted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_mask | input | 16 | Byte lanes written within the line |
| st_data | input | 128 | Store data, lane-aligned |
| st_cacheable | input | 1 | Store targets a cacheable page |
| st_side_effect | input | 1 | Store targets a side-effect page |
| ld_valid | input | 1 | Load presented |
| ld_addr | input | ADDR_W | Load byte address |
| ld_cacheable | input | 1 | Load targets a cacheable page |
| ld_side_effect | input | 1 | Load targets a side-effect page |
| ld_nonfaulting | input | 1 | Load is speculative, non-faulting |
| ctl_resolved | input | 1 | All earlier control transfers and exceptions resolved |
| ld_grant | output | 1 | Load issues this cycle |
| flt_valid | output | 1 | Fault pulse for a rejected speculative load |
| flt_code | output | 2 | Fault type (2 = speculative load to side-effect page) |
| flt_addr | output | ADDR_W | Address of the faulting load |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | ADDR_W | Line-aligned address of the offered entry |
| mem_mask | output | 16 | Byte mask of the offered entry |
| mem_data | output | 128 | Data of the offered entry |
| mem_uncached | output | 1 | Offered entry is noncacheable |

## Verification
The directed phase holds the memory port stalled and sends three cacheable stores to one line. The second of them must not merge, because the only pending entry is the one being offered. The third must merge into the entry that the second one started. This separates merging into the youngest entry from merging into the head. Two equal noncacheable stores to one line then have to produce two separate entries. With the queue full, a store to a new line and a cacheable store behind a noncacheable entry must both stall. Loads are then tried against the full queue, one per hazard kind, and a clean line must still be granted. After the drain, a side-effect load is toggled against `ctl_resolved`. A long random phase confines addresses to three lines and mixes every flag, so merges, stalls, line hazards and faults also occur together with memory backpressure.

// File: rtl/sefx_sb_pkg.sv
// Shared constants for the side-effect-aware store buffer.
// Assumes: none; holds only the fault-code encoding.
package sefx_sb_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_SPEC_SE = 2'd2
    } flt_code_e;
endpackage

// File: rtl/sefx_sb_queue.sv
// In-order entry queue with youngest-entry merging.
// A store merges only into the youngest pending entry, only when the store is
// cacheable, that entry is cacheable, covers the same line and is not the head
// (the head is always offered to memory). Otherwise a store takes a new slot.
// Assumes: DEPTH is a power of two and at least 2.
module sefx_sb_queue #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 28,
    parameter int MASK_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_valid,
    input  logic [LINE_W-1:0]              push_line,
    input  logic [MASK_W-1:0]              push_mask,
    input  logic [MASK_W*8-1:0]            push_data,
    input  logic                           push_nc,
    output logic                           push_ready,
    input  logic                           pop_req,
    output logic                           head_vld,
    output logic [LINE_W-1:0]              head_line,
    output logic [MASK_W-1:0]              head_mask,
    output logic [MASK_W*8-1:0]            head_data,
    output logic                           head_nc,
    output logic [DEPTH-1:0]               ent_vld,
    output logic [DEPTH-1:0]               ent_nc,
    output logic [DEPTH-1:0][LINE_W-1:0]   ent_line
);
    localparam int DATA_W = MASK_W * 8;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [LINE_W-1:0] line_q [DEPTH];
    logic [MASK_W-1:0] mask_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  nc_q;
    logic [PTR_W-1:0]  head_q, tail_q, young;
    logic [CNT_W-1:0]  count_q;
    logic              merge_ok, room, do_merge, do_alloc, do_pop;
    logic [DATA_W-1:0] merge_data;

    // Slot of the most recently allocated entry.
    assign young = tail_q - PTR_W'(1);

    // Merge eligibility and acceptance decisions.
    always_comb begin
        merge_ok = !push_nc && (count_q >= CNT_W'(2)) && !nc_q[young]
                   && (line_q[young] == push_line);
        room     = count_q < CNT_W'(DEPTH);
        do_merge = push_valid && merge_ok;
        do_alloc = push_valid && !merge_ok && room;
        do_pop   = pop_req && vld_q[head_q];
    end
    assign push_ready = merge_ok || room;

    // Byte-wise combination: new lanes replace old ones.
    for (genvar b = 0; b < MASK_W; b++) begin : g_lane
        assign merge_data[b*8 +: 8] = push_mask[b] ? push_data[b*8 +: 8]
                                                   : data_q[young][b*8 +: 8];
    end

    // Entry payload storage; no reset needed, validity is tracked apart.
    always_ff @(posedge clk) begin
        if (do_merge) begin
            mask_q[young] <= mask_q[young] | push_mask;
            data_q[young] <= merge_data;
        end
        if (do_alloc) begin
            line_q[tail_q] <= push_line;
            mask_q[tail_q] <= push_mask;
            data_q[tail_q] <= push_data;
            nc_q[tail_q]   <= push_nc;
        end
    end

    // Pointer, occupancy and validity bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_alloc) begin
                vld_q[tail_q] <= 1'b1;
                tail_q        <= tail_q + PTR_W'(1);
            end
            if (do_pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= head_q + PTR_W'(1);
            end
            count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(do_pop);
        end
    end

    assign head_vld  = vld_q[head_q];
    assign head_line = line_q[head_q];
    assign head_mask = mask_q[head_q];
    assign head_data = data_q[head_q];
    assign head_nc   = nc_q[head_q];
    assign ent_vld   = vld_q;
    assign ent_nc    = nc_q;

    // Flatten the line tags for the load hazard check.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tag
        assign ent_line[i] = line_q[i];
    end
endmodule

// File: rtl/sefx_sb_load_gate.sv
// Load issue gate: decides in the presenting cycle whether a load may issue
// and raises the fault for speculative loads to side-effect pages.
// Assumes: the entry view reflects the queue at the start of the cycle; a store
// accepted in the same cycle counts as younger than the load.
module sefx_sb_load_gate
    import sefx_sb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 28
) (
    input  logic                         ld_valid,
    input  logic [LINE_W-1:0]            ld_line,
    input  logic                         ld_cacheable,
    input  logic                         ld_side_effect,
    input  logic                         ld_nonfaulting,
    input  logic                         ctl_resolved,
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0]             ent_nc,
    input  logic [DEPTH-1:0][LINE_W-1:0] ent_line,
    output logic                         ld_grant,
    output logic                         flt_valid,
    output logic [1:0]                   flt_code
);
    logic [DEPTH-1:0] line_hit, nc_hit;
    logic             spec_bad, hold;

    // Per-entry hazard detection.
    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign line_hit[i] = ent_vld[i] && (ent_line[i] == ld_line);
        assign nc_hit[i]   = ent_vld[i] && ent_nc[i];
    end

    // Combine hazards into grant and fault decisions.
    always_comb begin
        spec_bad  = ld_nonfaulting && ld_side_effect;
        hold      = ld_cacheable ? (|line_hit)
                                 : ((|nc_hit) || (ld_side_effect && !ctl_resolved));
        flt_valid = ld_valid && spec_bad;
        flt_code  = flt_valid ? FLT_SPEC_SE : FLT_NONE;
        ld_grant  = ld_valid && !spec_bad && !hold;
    end
endmodule

// File: rtl/sefx_store_buffer.sv
// Side-effect-aware store buffer top: wires the entry queue to the memory port
// and the load gate to the pending-entry view.
// Assumes: LINE_BYTES is a power of two; stores and loads never cross a line.
module sefx_store_buffer #(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [LINE_BYTES-1:0]   st_mask,
    input  logic [LINE_BYTES*8-1:0] st_data,
    input  logic                    st_cacheable,
    input  logic                    st_side_effect,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic                    ld_cacheable,
    input  logic                    ld_side_effect,
    input  logic                    ld_nonfaulting,
    input  logic                    ctl_resolved,
    output logic                    ld_grant,
    output logic                    flt_valid,
    output logic [1:0]              flt_code,
    output logic [ADDR_W-1:0]       flt_addr,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES-1:0]   mem_mask,
    output logic [LINE_BYTES*8-1:0] mem_data,
    output logic                    mem_uncached
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [DEPTH-1:0]             ent_vld, ent_nc;
    logic [DEPTH-1:0][LINE_W-1:0] ent_line;
    logic [LINE_W-1:0]            head_line;
    logic                         unused_st_bits;

    // Offsets within a line and the side-effect flag do not change store handling.
    assign unused_st_bits = ^{st_addr[OFF_W-1:0], st_side_effect};

    sefx_sb_queue #(
        .DEPTH (DEPTH),
        .LINE_W(LINE_W),
        .MASK_W(LINE_BYTES)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(st_valid),
        .push_line (st_addr[ADDR_W-1:OFF_W]),
        .push_mask (st_mask),
        .push_data (st_data),
        .push_nc   (!st_cacheable),
        .push_ready(st_ready),
        .pop_req   (mem_ready),
        .head_vld  (mem_valid),
        .head_line (head_line),
        .head_mask (mem_mask),
        .head_data (mem_data),
        .head_nc   (mem_uncached),
        .ent_vld   (ent_vld),
        .ent_nc    (ent_nc),
        .ent_line  (ent_line)
    );

    sefx_sb_load_gate #(
        .DEPTH (DEPTH),
        .LINE_W(LINE_W)
    ) u_gate (
        .ld_valid      (ld_valid),
        .ld_line       (ld_addr[ADDR_W-1:OFF_W]),
        .ld_cacheable  (ld_cacheable),
        .ld_side_effect(ld_side_effect),
        .ld_nonfaulting(ld_nonfaulting),
        .ctl_resolved  (ctl_resolved),
        .ent_vld       (ent_vld),
        .ent_nc        (ent_nc),
        .ent_line      (ent_line),
        .ld_grant      (ld_grant),
        .flt_valid     (flt_valid),
        .flt_code      (flt_code)
    );

    // Fault address follows the presented load only while the fault is raised.
    assign flt_addr = flt_valid ? ld_addr : '0;
    assign mem_addr = {head_line, {OFF_W{1'b0}}};
endmodule

// File: rtl/sefx_store_buffer_chk.sv
// Property checker for the store buffer, bound onto every instance of the top.
// Assumes: the bind below supplies the internal entry view.
module sefx_store_buffer_chk #(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 4,
    parameter int LINE_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_ready,
    input logic                    ld_grant,
    input logic                    ld_cacheable,
    input logic                    ld_side_effect,
    input logic                    ctl_resolved,
    input logic                    flt_valid,
    input logic [1:0]              flt_code,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [LINE_BYTES-1:0]   mem_mask,
    input logic [LINE_BYTES*8-1:0] mem_data,
    input logic [DEPTH-1:0]        ent_vld,
    input logic [DEPTH-1:0]        ent_nc
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    // R8
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_code == 2'd2) && !ld_grant);

    // R7
    se_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_grant && !ld_cacheable && ld_side_effect) |-> ctl_resolved);

    // R6
    nc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_grant && !ld_cacheable) |-> !(|(ent_vld & ent_nc)));

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr)
            && $stable(mem_mask) && $stable(mem_data));

    // R4
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (&ent_vld));
endmodule

bind sefx_store_buffer sefx_store_buffer_chk #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_ready      (st_ready),
    .ld_grant      (ld_grant),
    .ld_cacheable  (ld_cacheable),
    .ld_side_effect(ld_side_effect),
    .ctl_resolved  (ctl_resolved),
    .flt_valid     (flt_valid),
    .flt_code      (flt_code),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_mask      (mem_mask),
    .mem_data      (mem_data),
    .ent_vld       (ent_vld),
    .ent_nc        (ent_nc)
);

// File: tb/sefx_store_buffer_bench.sv
// Bench: behavioural queue model compared against the design every cycle.
module sefx_store_buffer_bench;
    localparam int AW = 32;

    typedef struct {
        logic [27:0]  line;
        logic [15:0]  mask;
        logic [127:0] data;
        bit           nc;
    } ent_t;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         st_valid = 0, st_cacheable = 0, st_side_effect = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [15:0]  st_mask = '0;
    logic [127:0] st_data = '0;
    logic         ld_valid = 0, ld_cacheable = 0, ld_side_effect = 0, ld_nonfaulting = 0;
    logic         ctl_resolved = 1, mem_ready = 0;
    logic         st_ready, ld_grant, flt_valid, mem_valid, mem_uncached;
    logic [1:0]   flt_code;
    logic [AW-1:0] flt_addr, mem_addr;
    logic [15:0]  mem_mask;
    logic [127:0] mem_data;

    int   errors = 0, checks = 0;
    ent_t mq[$];
    bit   after_reset = 0;

    always #10 clk = ~clk;

    sefx_store_buffer u_sefx_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_mask(st_mask), .st_data(st_data), .st_cacheable(st_cacheable),
        .st_side_effect(st_side_effect),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_cacheable(ld_cacheable),
        .ld_side_effect(ld_side_effect), .ld_nonfaulting(ld_nonfaulting),
        .ctl_resolved(ctl_resolved), .ld_grant(ld_grant),
        .flt_valid(flt_valid), .flt_code(flt_code), .flt_addr(flt_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_mask(mem_mask), .mem_data(mem_data), .mem_uncached(mem_uncached)
    );

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: compare outputs against the model, then advance the model.
    task automatic step();
        int  n;
        bit  m_ok, e_merge, e_alloc, e_pop, e_flt, e_grant;
        string gtag;
        #1;
        n    = mq.size();
        m_ok = st_cacheable && n >= 2 && !mq[n-1].nc && mq[n-1].line == st_addr[31:4];
        e_merge = st_valid && m_ok;
        e_alloc = st_valid && !m_ok && n < 4;
        e_pop   = n > 0 && mem_ready;
        e_flt   = ld_valid && ld_nonfaulting && ld_side_effect;
        e_grant = 0;
        gtag    = "R10";
        if (e_flt) gtag = "R8";
        else if (!ld_cacheable) begin
            bit ncp = 0;
            foreach (mq[i]) if (mq[i].nc) ncp = 1;
            if (ncp) gtag = "R6";
            else if (ld_side_effect && !ctl_resolved) gtag = "R7";
        end else begin
            foreach (mq[i]) if (mq[i].line == ld_addr[31:4]) gtag = "R9";
        end
        e_grant = ld_valid && gtag == "R10";
        chk(after_reset ? "R1" : "R5", "st_ready", st_ready, (m_ok || n < 4));
        chk(after_reset ? "R1" : "R4", "mem_valid", mem_valid, n > 0);
        chk(after_reset ? "R1" : "R8", "flt_valid", flt_valid, e_flt);
        chk(ld_valid ? gtag : "R10", "ld_grant", ld_grant, e_grant);
        if (e_flt) begin
            chk("R8", "flt_code", flt_code, 2'd2);
            chk("R8", "flt_addr", flt_addr, ld_addr);
        end
        if (n > 0) begin
            chk("R4", "mem_addr", mem_addr, {mq[0].line, 4'b0});
            chk("R2", "mem_mask", mem_mask, mq[0].mask);
            chk("R2", "mem_data", mem_data, mq[0].data);
            chk("R3", "mem_uncached", mem_uncached, mq[0].nc);
        end
        after_reset = 0;
        @(posedge clk);
        if (e_merge) begin
            for (int b = 0; b < 16; b++)
                if (st_mask[b]) mq[n-1].data[b*8 +: 8] = st_data[b*8 +: 8];
            mq[n-1].mask = mq[n-1].mask | st_mask;
        end
        if (e_pop) void'(mq.pop_front());
        if (e_alloc) begin
            ent_t e;
            e.line = st_addr[31:4]; e.mask = st_mask; e.data = st_data; e.nc = !st_cacheable;
            mq.push_back(e);
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        st_valid = 0; ld_valid = 0; ld_nonfaulting = 0;
    endtask

    task automatic put_st(logic [27:0] line, logic [15:0] m, bit cach);
        idle_in();
        st_valid = 1; st_addr = {line, 4'h5}; st_mask = m; st_cacheable = cach;
        st_side_effect = !cach; st_data = {$urandom, $urandom, $urandom, $urandom};
        step();
    endtask

    task automatic put_ld(logic [27:0] line, bit cach, bit se, bit nf, bit res);
        idle_in();
        ld_valid = 1; ld_addr = {line, 4'h8}; ld_cacheable = cach;
        ld_side_effect = se; ld_nonfaulting = nf; ctl_resolved = res;
        step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        after_reset = 1;
        step();                               // R1 reset state
        mem_ready = 0;
        put_st(28'h100, 16'h000F, 1);         // first entry
        put_st(28'h100, 16'h00F0, 1);         // R2: head only, no merge
        put_st(28'h100, 16'hFF00, 1);         // R2: merges into second entry
        put_st(28'h200, 16'h0003, 0);         // R3: noncacheable
        put_st(28'h200, 16'h0003, 0);         // R3: separate entry
        put_st(28'h300, 16'h0001, 1);         // R5: full stall
        put_st(28'h200, 16'h0001, 1);         // R5: youngest is noncacheable
        put_ld(28'h100, 1, 0, 0, 1);          // R9 line hazard
        put_ld(28'h333, 1, 0, 0, 1);          // R10 clean line
        put_ld(28'h444, 0, 0, 0, 1);          // R6 noncacheable store pending
        put_ld(28'h444, 0, 1, 1, 1);          // R8 fault
        idle_in(); mem_ready = 1;
        repeat (5) step();                    // R4 drain order
        mem_ready = 0;
        put_ld(28'h555, 0, 1, 0, 0);          // R7 waits for resolution
        put_ld(28'h555, 0, 1, 0, 1);          // R7 resolved, R10 granted
        for (int k = 0; k < 3000; k++) begin
            st_valid = ($urandom % 2) == 0;
            st_addr = {28'h10 + 28'($urandom % 3), 4'($urandom)};
            st_mask = 16'($urandom) | 16'h1;
            st_data = {$urandom, $urandom, $urandom, $urandom};
            st_cacheable = ($urandom % 4) != 0;
            st_side_effect = ($urandom % 2) == 0;
            ld_valid = ($urandom % 5) < 2;
            ld_addr = {28'h10 + 28'($urandom % 4), 4'($urandom)};
            ld_cacheable = ($urandom % 2) == 0;
            ld_side_effect = ($urandom % 2) == 0;
            ld_nonfaulting = ($urandom % 4) == 0;
            ctl_resolved = ($urandom % 10) < 7;
            mem_ready = ($urandom % 2) == 0;
            step();
        end
        summary();
        $finish;
    end
endmodule